// File: doc/BRIEF.md
# Transaction Identifier Filter

This block decides whether one translated transaction qualifies for a performance counter whose selector carries identifier filters. It takes the filter fields of that selector and the identifiers of the transaction, and returns a single match bit. Two identifier pairs are available. One is the requester's device number together with its process number. The other is the guest context tag together with the process context tag. A type-select bit picks which pair is compared.

The device comparison can cover a range of identifiers. When the range enable is set, the compare value itself sets the width of the range. The run of ones at its low end, and the first zero bit above that run, are ignored in the comparison. A naturally aligned power-of-two range is therefore written by filling its low bits with ones followed by one zero. The decision is combinational. A parameter can add a register stage on the match output. Event selection and counting are handled outside this block.

Top module: `txn_id_filter`

## Requirements
- R1: When `idTypeSel` is 1, the device-side identifier compared is `txnGscid` and the process-side identifier is `txnPscid`. When it is 0, they are `txnDevId` and `txnPid`.
- R2: When `pidFiltEn` is 1 and `txnPidValid` is 1, the process check passes only if `fltPid` equals the selected process-side identifier.
- R3: When `pidFiltEn` is 1 and `txnPidValid` is 0, the process check passes whatever `fltPid` holds.
- R4: When `devFiltEn` is 1 and `devMaskEn` is 0, the device check passes only if all 24 bits of `fltDid` equal the selected device-side identifier.
- R5: When `devFiltEn` and `devMaskEn` are both 1, the compare mask is the complement of v XOR (v+1), where v is `fltDid`. Bits where the mask is 0 are ignored. For example, v = 0x00009B ignores bits 2:0.
- R6: When `devFiltEn` and `devMaskEn` are both 1 and `fltDid` is all ones, every device-side identifier matches.
- R7: When `pidFiltEn` and `devFiltEn` are both 0, `match` is 1.
- R8: `match` is the AND of the process check and the device check. A check whose enable is 0 passes.
- R9: Guest context tags narrower than 24 bits and process context tags narrower than 20 bits are zero-extended before they are compared.
- R10: With `OUT_REG` = 1, `match` shows the decision for the inputs sampled at the previous rising clock edge, and it is 0 while `rstN` is low. With `OUT_REG` = 0, `match` follows the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low asynchronous reset |
| idTypeSel | input | 1 | 1 selects the context tags, 0 selects the device and process numbers |
| pidFiltEn | input | 1 | Enables the process-side filter |
| devFiltEn | input | 1 | Enables the device-side filter |
| devMaskEn | input | 1 | Enables range matching on the device side |
| fltDid | input | 24 | Device-side compare value from the selector |
| fltPid | input | 20 | Process-side compare value from the selector |
| txnDevId | input | 24 | Device number of the transaction |
| txnPid | input | 20 | Process number of the transaction |
| txnPidValid | input | 1 | Transaction carries a valid process number |
| txnGscid | input | 16 | Guest context tag of the transaction |
| txnPscid | input | 20 | Process context tag of the transaction |
| match | output | 1 | Transaction qualifies for the counter |

## Verification
The assertions check on every cycle that:
- a disabled filter never blocks a match;
- the range mask always covers a contiguous low run of bits;
- the registered output equals the previous cycle's decision from the datapath.

Only the bench's scenarios can show that the right identifier pair is chosen. The same holds for the exact width of the ignored run for a given compare value, and for a process check with no valid process number passing even when the values differ. These are checked against a bench model, using directed corners and seeded random values.

// File: rtl/txn_id_filter_pkg.sv
package txn_id_filter_pkg;
  localparam int DID_W = 24;
  localparam int PID_W = 20;

  typedef struct packed {
    logic useCtx;
    logic pidChk;
    logic didChk;
    logic useRange;
    logic pidPresent;
  } fltCtrl_t;
endpackage

// File: rtl/txn_id_filter_ctrl.sv
module txn_id_filter_ctrl
  import txn_id_filter_pkg::*;
(
  input  logic     idTypeSel,
  input  logic     pidFiltEn,
  input  logic     devFiltEn,
  input  logic     devMaskEn,
  input  logic     txnPidValid,
  output fltCtrl_t ctrl
);
  always_comb begin
    ctrl.useCtx     = idTypeSel;
    ctrl.pidChk     = pidFiltEn & txnPidValid;
    ctrl.didChk     = devFiltEn;
    ctrl.useRange   = devFiltEn & devMaskEn;
    ctrl.pidPresent = txnPidValid;
  end

  always_comb begin
    a_r3_pid_needs_valid: assert (!(ctrl.pidChk && !txnPidValid))
      else $error("process check armed without valid process number");
  end
endmodule

// File: rtl/txn_id_filter_dp.sv
module txn_id_filter_dp
  import txn_id_filter_pkg::*;
#(
  parameter int DW  = DID_W,
  parameter int PW  = PID_W,
  parameter int GW  = 16,
  parameter int CPW = 20
) (
  input  fltCtrl_t          ctrl,
  input  logic [DW-1:0]     fltDid,
  input  logic [PW-1:0]     fltPid,
  input  logic [DW-1:0]     txnDevId,
  input  logic [PW-1:0]     txnPid,
  input  logic [GW-1:0]     txnGscid,
  input  logic [CPW-1:0]    txnPscid,
  output logic [DW-1:0]     cmpMask,
  output logic              pidOk,
  output logic              didOk
);
  logic [DW-1:0] selDid;
  logic [PW-1:0] selPid;
  logic [DW-1:0] gscExt;
  logic [PW-1:0] pscExt;

  generate
    if (GW < DW) begin : g_gpad
      assign gscExt = {{(DW-GW){1'b0}}, txnGscid};
    end else begin : g_gcut
      assign gscExt = txnGscid[DW-1:0];
    end
    if (CPW < PW) begin : g_ppad
      assign pscExt = {{(PW-CPW){1'b0}}, txnPscid};
    end else begin : g_pcut
      assign pscExt = txnPscid[PW-1:0];
    end
  endgenerate

  assign selDid = ctrl.useCtx ? gscExt : txnDevId;
  assign selPid = ctrl.useCtx ? pscExt : txnPid;

  logic [DW-1:0] dontCare;
  assign dontCare = fltDid ^ (fltDid + 1'b1);
  assign cmpMask  = ctrl.useRange ? ~dontCare : {DW{1'b1}};

  assign pidOk = !ctrl.pidChk || (fltPid == selPid);
  assign didOk = !ctrl.didChk || ((fltDid & cmpMask) == (selDid & cmpMask));

  // The mask must be a contiguous run of ones at the top (R5)
  always_comb begin
    a_r5_mask_contig: assert (((~cmpMask) & ((~cmpMask) + 1'b1)) == '0)
      else $error("range mask not contiguous");
    a_r8_disabled_pass: assert (ctrl.didChk || didOk)
      else $error("disabled device check blocked");
  end
endmodule

// File: rtl/txn_id_filter.sv
module txn_id_filter
  import txn_id_filter_pkg::*;
#(
  parameter int GSC_W   = 16,
  parameter int PSC_W   = 20,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                idTypeSel,
  input  logic                pidFiltEn,
  input  logic                devFiltEn,
  input  logic                devMaskEn,
  input  logic [DID_W-1:0]    fltDid,
  input  logic [PID_W-1:0]    fltPid,
  input  logic [DID_W-1:0]    txnDevId,
  input  logic [PID_W-1:0]    txnPid,
  input  logic                txnPidValid,
  input  logic [GSC_W-1:0]    txnGscid,
  input  logic [PSC_W-1:0]    txnPscid,
  output logic                match
);
  fltCtrl_t      ctrl;
  logic [DID_W-1:0] cmpMask;
  logic          pidOk, didOk, matchNow;

  txn_id_filter_ctrl u_ctrl (
    .idTypeSel(idTypeSel), .pidFiltEn(pidFiltEn), .devFiltEn(devFiltEn),
    .devMaskEn(devMaskEn), .txnPidValid(txnPidValid), .ctrl(ctrl)
  );

  txn_id_filter_dp #(.DW(DID_W), .PW(PID_W), .GW(GSC_W), .CPW(PSC_W)) u_dp (
    .ctrl(ctrl), .fltDid(fltDid), .fltPid(fltPid), .txnDevId(txnDevId),
    .txnPid(txnPid), .txnGscid(txnGscid), .txnPscid(txnPscid),
    .cmpMask(cmpMask), .pidOk(pidOk), .didOk(didOk)
  );

  assign matchNow = pidOk & didOk;

  generate
    if (OUT_REG) begin : g_reg
      logic matchQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) matchQ <= 1'b0;
        else       matchQ <= matchNow;
      end
      assign match = matchQ;

      a_r10_reg_delay: assert property (@(posedge clk) disable iff (!rstN)
        1'b1 |=> (match == $past(matchNow)))
        else $error("registered match lags wrong");
    end else begin : g_comb
      assign match = matchNow;
    end
  endgenerate

  a_r7_no_filter: assert property (@(posedge clk) disable iff (!rstN)
    (!pidFiltEn && !devFiltEn) |-> matchNow)
    else $error("unfiltered transaction rejected");
  a_r6_all_ones: assert property (@(posedge clk) disable iff (!rstN)
    (devFiltEn && devMaskEn && (&fltDid) && !pidFiltEn) |-> matchNow)
    else $error("all-ones range did not match");
endmodule

// File: tb/txn_id_filter_tb.sv
module txn_id_filter_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rstN = 0;
  logic idTypeSel, pidFiltEn, devFiltEn, devMaskEn, txnPidValid;
  logic [23:0] fltDid, txnDevId;
  logic [19:0] fltPid, txnPid, txnPscid;
  logic [15:0] txnGscid;
  logic match;
  int nChk = 0, nFail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txn_id_filter dut_i (.*);

  function automatic bit model();
    logic [23:0] d, m;
    logic [19:0] p;
    bit pOk, dOk;
    d = idTypeSel ? {8'h0, txnGscid} : txnDevId;
    p = idTypeSel ? txnPscid : txnPid;
    m = devMaskEn ? ~(fltDid ^ (fltDid + 24'd1)) : 24'hFFFFFF;
    pOk = !(pidFiltEn && txnPidValid) || (fltPid == p);
    dOk = !devFiltEn || ((fltDid & m) == (d & m));
    return pOk && dOk;
  endfunction

  task automatic check(string req, logic exp);
    nChk++;
    if (match !== exp) begin
      nFail++;
      $display("FAIL %s: match=%b expected=%b", req, match, exp);
    end
  endtask

  // apply stimulus, then sample one cycle later away from the edge
  task automatic run(string req);
    logic e;
    @(negedge clk);
    e = model();
    @(negedge clk);
    check(req, e);
  endtask

  task automatic clr();
    idTypeSel = 0; pidFiltEn = 0; devFiltEn = 0; devMaskEn = 0; txnPidValid = 0;
    fltDid = 0; fltPid = 0; txnDevId = 0; txnPid = 0; txnGscid = 0; txnPscid = 0;
  endtask

  task automatic dir(string req, logic exp);
    @(negedge clk);
    @(negedge clk);
    check(req, exp);
  endtask

  initial begin
    clr();
    #(CLK_PERIOD*2);
    check("R10 reset", 1'b0);
    @(negedge clk) rstN = 1;
    // R7
    txnDevId = 24'h123456; fltDid = 24'h000001;
    dir("R7", 1'b1);
    // R4 exact
    devFiltEn = 1; fltDid = 24'h123456; dir("R4 equal", 1'b1);
    txnDevId = 24'h123457; dir("R4 differ", 1'b0);
    // R5 range
    devMaskEn = 1; fltDid = 24'h00009B; txnDevId = 24'h000098; dir("R5 low3 ignored", 1'b1);
    txnDevId = 24'h00009F; dir("R5 in range", 1'b1);
    txnDevId = 24'h0000A0; dir("R5 out of range", 1'b0);
    fltDid = 24'h000010; txnDevId = 24'h000011; dir("R5 zero lsb", 1'b1);
    txnDevId = 24'h000012; dir("R5 zero lsb out", 1'b0);
    // R6
    fltDid = 24'hFFFFFF; txnDevId = 24'hABCDEF; dir("R6", 1'b1);
    // R1 / R9 context selection
    clr(); devFiltEn = 1; idTypeSel = 1; txnGscid = 16'h5A5A; txnDevId = 24'h777777;
    fltDid = 24'h005A5A; dir("R1 R9 ctx dev", 1'b1);
    fltDid = 24'h777777; dir("R1 ctx ignores devid", 1'b0);
    // R2 / R3
    clr(); pidFiltEn = 1; txnPidValid = 1; fltPid = 20'h0ABCD; txnPid = 20'h0ABCD;
    dir("R2 equal", 1'b1);
    txnPid = 20'h0ABCE; dir("R2 differ", 1'b0);
    txnPidValid = 0; dir("R3 no valid pid", 1'b1);
    idTypeSel = 1; txnPidValid = 1; txnPscid = 20'h0ABCD; dir("R1 ctx pid", 1'b1);
    // R8
    devFiltEn = 1; fltDid = 24'h1; txnGscid = 16'h2; dir("R8 and", 1'b0);
    // random
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      idTypeSel = $urandom; pidFiltEn = $urandom; devFiltEn = $urandom;
      devMaskEn = $urandom; txnPidValid = $urandom;
      fltDid = $urandom; txnDevId = ($urandom & 1) ? fltDid ^ ($urandom & 24'h7) : 24'($urandom);
      fltPid = $urandom; txnPid = ($urandom & 1) ? fltPid : 20'($urandom);
      txnGscid = ($urandom & 1) ? fltDid[15:0] : 16'($urandom);
      txnPscid = ($urandom & 1) ? fltPid : 20'($urandom);
      run("R8 random");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_PERIOD*100000);
        nChk++; nFail++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule